// File: doc/BRIEF.md
# Parallel Sampling-Converter Sequencer

This block drives a 16-bit sampling converter through its parallel port. A one-cycle `start_i` request makes it lower chip select and wait out a settling interval. It then lowers the conversion strobe for a minimum width. Next it waits for the converter's busy flag to fall. Finally it reads the result with chip select and read low. The read is either one full word, or two bytes taken over the upper eight data lines, with a byte-select line picking which half is presented.

Every nanosecond limit is turned into a whole number of clock cycles from a clock-period parameter, rounding up. Reads are kept out of a quiet interval on both sides of the falling conversion strobe. After reset, the first three results are read but not passed on. Each later result appears unchanged on `smp_o`, in straight binary, with a single-cycle `smp_vld_o` pulse. If busy never falls within a cycle budget, the block pulses `busy_tmo_o`, releases all strobes and returns to idle.

Top module: `adc_par_ctrl`

## Requirements
- R1: With default parameters (4 ns clock), `conv_n_o` stays low for at least 5 consecutive cycles per conversion, and `cs_n_o` is low in the cycle where `conv_n_o` falls.
- R2: `rd_n_o` only falls once `busy_i` has fallen after the conversion start, and no earlier than 10 cycles after the falling edge of `conv_n_o`. `busy_i` is low while `rd_n_o` is low.
- R3: `conv_n_o` never falls within 13 cycles after a rising edge of `rd_n_o`.
- R4: Word mode (`byte_mode_i`=0) performs one read with `byte_sel_o` low and delivers `db_i[15:0]` as the sample.
- R5: Byte mode (`byte_mode_i`=1) takes `db_i[15:8]` with `byte_sel_o`=0 as sample bits 15..8, then `db_i[15:8]` with `byte_sel_o`=1 as sample bits 7..0.
- R6: In byte mode with `rd_hold_i`=1, `rd_n_o` falls once and stays low across both bytes. With `rd_hold_i`=0 it rises between the bytes and falls twice. Word mode always gives one falling edge.
- R7: The first three completed reads after reset raise no `smp_vld_o`. The fourth and later reads do.
- R8: `smp_vld_o` is a one-cycle pulse, once per delivered sample. Codes pass unchanged, including 0x0000 and 0xFFFF.
- R9: If `busy_i` has not fallen 1024 cycles after the conversion start, `busy_tmo_o` pulses for one cycle. No read and no `smp_vld_o` follow, the block returns to ready, and the next conversion works normally.
- R10: `start_i` while `ready_o` is low is ignored: it neither starts nor queues a conversion.
- R11: During and right after reset, `conv_n_o`, `cs_n_o` and `rd_n_o` are high, `byte_sel_o`, `smp_vld_o`, `busy_tmo_o` are low, `smp_o` is zero and `ready_o` is high.
- R12: `rd_n_o` is low only while `cs_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion (taken only when ready) |
| byte_mode_i | input | 1 | 1: two byte reads over the upper lanes; 0: one word read |
| rd_hold_i | input | 1 | Byte mode: 1 holds read low across both bytes, 0 toggles it |
| busy_i | input | 1 | Converter busy flag |
| db_i | input | 16 | Converter data lines |
| conv_n_o | output | 1 | Conversion-start strobe, active low |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| byte_sel_o | output | 1 | Byte select: 1 presents the low byte on the upper lines |
| smp_o | output | 16 | Last delivered sample |
| smp_vld_o | output | 1 | One-cycle sample-valid pulse |
| busy_tmo_o | output | 1 | One-cycle pulse when busy never falls |
| ready_o | output | 1 | Idle and able to accept `start_i` |

## Verification
The hardest case to reach is a conversion so short that busy rises and falls while the start strobe is still low. In that case the fall has to be remembered, and the read must still wait for the quiet interval after the strobe edge. The bench's converter model takes a per-vector busy length of one to three cycles to reach it. A stuck-busy switch in the same model produces the timeout and the recovery after it. A second reset partway through the run shows that the three-result discard starts over.

// File: rtl/adc_par_pkg.sv
package adc_par_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETUP,
        S_CONV,
        S_WAIT,
        S_RDA,
        S_GAP,
        S_RDB,
        S_DONE,
        S_ERR
    } seq_st_e;

    typedef struct packed {
        logic conv_n;
        logic cs_n;
        logic rd_n;
        logic bsel;
    } strb_t;

    typedef struct packed {
        logic word;
        logic hi;
        logic lo;
    } cap_t;

    localparam strb_t STRB_IDLE = '{conv_n: 1'b1, cs_n: 1'b1, rd_n: 1'b1, bsel: 1'b0};

    // ceiling division of a time limit by the clock period, at least one cycle
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_par_seq.sv
module adc_par_seq
    import adc_par_pkg::*;
#(
    parameter int CONV_CYC = 5,
    parameter int PRE_CYC  = 13,
    parameter int POST_CYC = 10,
    parameter int RD_CYC   = 5,
    parameter int TMO_CYC  = 1024
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  byte_mode_i,
    input  logic  rd_hold_i,
    input  logic  busy_i,
    output strb_t strb_o,
    output cap_t  cap_o,
    output logic  done_o,
    output logic  err_o,
    output logic  ready_o
);

    localparam int TMAX = max3(CONV_CYC, PRE_CYC, RD_CYC);
    localparam int TW   = $clog2(TMAX + 1);
    localparam int CLIM = (TMO_CYC > POST_CYC) ? TMO_CYC : POST_CYC;
    localparam int CW   = $clog2(CLIM + 1);

    seq_st_e        st, st_nx;
    logic [TW-1:0]  tmr;
    logic [CW-1:0]  since_cv;
    logic           busy_q, fell_seen, m_byte, m_hold;
    logic           busy_fall, tmr_end, post_ok, go_read, tmo_hit, enter_conv;

    assign busy_fall  = busy_q & ~busy_i;
    assign post_ok    = since_cv >= CW'(POST_CYC);
    assign go_read    = (fell_seen | busy_fall) & post_ok;
    assign tmo_hit    = since_cv >= CW'(TMO_CYC);
    assign enter_conv = (st_nx == S_CONV) && (st != S_CONV);

    always_comb begin
        case (st)
            S_SETUP:      tmr_end = (tmr == TW'(PRE_CYC - 1));
            S_CONV:       tmr_end = (tmr == TW'(CONV_CYC - 1));
            S_RDA, S_RDB: tmr_end = (tmr == TW'(RD_CYC - 1));
            default:      tmr_end = 1'b1;
        endcase
    end

    always_comb begin
        st_nx = st;
        case (st)
            S_IDLE:  if (start_i) st_nx = S_SETUP;
            S_SETUP: if (tmr_end) st_nx = S_CONV;
            S_CONV:  if (tmr_end) st_nx = S_WAIT;
            S_WAIT: begin
                if (go_read)      st_nx = S_RDA;
                else if (tmo_hit) st_nx = S_ERR;
            end
            S_RDA: begin
                if (tmr_end) begin
                    if (!m_byte)     st_nx = S_DONE;
                    else if (m_hold) st_nx = S_RDB;
                    else             st_nx = S_GAP;
                end
            end
            S_GAP:   st_nx = S_RDB;
            S_RDB:   if (tmr_end) st_nx = S_DONE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            tmr       <= '0;
            since_cv  <= '0;
            busy_q    <= 1'b0;
            fell_seen <= 1'b0;
            m_byte    <= 1'b0;
            m_hold    <= 1'b0;
        end else begin
            st     <= st_nx;
            tmr    <= (st_nx != st) ? '0 : tmr + 1'b1;
            busy_q <= busy_i;
            if (enter_conv)
                since_cv <= '0;
            else if (since_cv != CW'(CLIM))
                since_cv <= since_cv + 1'b1;
            if (enter_conv)
                fell_seen <= 1'b0;
            else if ((st == S_CONV || st == S_WAIT) && busy_fall)
                fell_seen <= 1'b1;
            if (st == S_IDLE && start_i) begin
                m_byte <= byte_mode_i;
                m_hold <= rd_hold_i;
            end
        end
    end

    always_comb begin
        strb_o = STRB_IDLE;
        case (st)
            S_SETUP, S_WAIT: strb_o.cs_n = 1'b0;
            S_CONV: begin
                strb_o.cs_n   = 1'b0;
                strb_o.conv_n = 1'b0;
            end
            S_RDA: begin
                strb_o.cs_n = 1'b0;
                strb_o.rd_n = 1'b0;
            end
            S_GAP: begin
                strb_o.cs_n = 1'b0;
                strb_o.bsel = 1'b1;
            end
            S_RDB: begin
                strb_o.cs_n = 1'b0;
                strb_o.rd_n = 1'b0;
                strb_o.bsel = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        cap_o      = '0;
        cap_o.word = (st == S_RDA) && tmr_end && !m_byte;
        cap_o.hi   = (st == S_RDA) && tmr_end &&  m_byte;
        cap_o.lo   = (st == S_RDB) && tmr_end;
    end

    assign done_o  = (st == S_DONE);
    assign err_o   = (st == S_ERR);
    assign ready_o = (st == S_IDLE);

endmodule

// File: rtl/adc_par_capture.sv
module adc_par_capture
    import adc_par_pkg::*;
#(
    parameter int DW   = 16,
    parameter int LANE = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  cap_t          cap_i,
    input  logic [DW-1:0] db_i,
    output logic [DW-1:0] data_o
);

    localparam int LO_W = DW - LANE;

    logic [LANE-1:0] up_lane;
    assign up_lane = db_i[DW-1 -: LANE];

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
        end else if (cap_i.word) begin
            data_o <= db_i;
        end else begin
            if (cap_i.hi) data_o[DW-1 -: LANE] <= up_lane;
            if (cap_i.lo) data_o[LO_W-1:0]     <= up_lane[LANE-1 -: LO_W];
        end
    end

endmodule

// File: rtl/adc_par_warmup.sv
module adc_par_warmup #(
    parameter int DISCARD = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic done_i,
    output logic vld_o
);

    localparam int WW = $clog2(DISCARD + 2);

    logic [WW-1:0] seen;
    logic          warm;

    assign warm  = (seen == WW'(DISCARD));
    assign vld_o = done_i & warm;

    always_ff @(posedge clk) begin
        if (rst)
            seen <= '0;
        else if (done_i && !warm)
            seen <= seen + 1'b1;
    end

endmodule

// File: rtl/adc_par_ctrl.sv
module adc_par_ctrl
    import adc_par_pkg::*;
#(
    parameter int CLK_NS   = 4,
    parameter int CONV_NS  = 20,
    parameter int PRE_NS   = 50,
    parameter int POST_NS  = 40,
    parameter int RD_NS    = 20,
    parameter int TMO_CYC  = 1024,
    parameter int DISCARD  = 3,
    parameter int DW       = 16,
    parameter int LANE     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          byte_mode_i,
    input  logic          rd_hold_i,
    input  logic          busy_i,
    input  logic [DW-1:0] db_i,
    output logic          conv_n_o,
    output logic          cs_n_o,
    output logic          rd_n_o,
    output logic          byte_sel_o,
    output logic [DW-1:0] smp_o,
    output logic          smp_vld_o,
    output logic          busy_tmo_o,
    output logic          ready_o
);

    localparam int CONV_CYC = ns_to_cyc(CONV_NS, CLK_NS);
    localparam int PRE_CYC  = ns_to_cyc(PRE_NS, CLK_NS);
    localparam int POST_CYC = ns_to_cyc(POST_NS, CLK_NS);
    localparam int RD_CYC   = ns_to_cyc(RD_NS, CLK_NS);

    strb_t strb;
    cap_t  cap;
    logic  done;

    adc_par_seq #(
        .CONV_CYC (CONV_CYC),
        .PRE_CYC  (PRE_CYC),
        .POST_CYC (POST_CYC),
        .RD_CYC   (RD_CYC),
        .TMO_CYC  (TMO_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .byte_mode_i (byte_mode_i),
        .rd_hold_i   (rd_hold_i),
        .busy_i      (busy_i),
        .strb_o      (strb),
        .cap_o       (cap),
        .done_o      (done),
        .err_o       (busy_tmo_o),
        .ready_o     (ready_o)
    );

    adc_par_capture #(
        .DW   (DW),
        .LANE (LANE)
    ) u_cap (
        .clk    (clk),
        .rst    (rst),
        .cap_i  (cap),
        .db_i   (db_i),
        .data_o (smp_o)
    );

    adc_par_warmup #(
        .DISCARD (DISCARD)
    ) u_warm (
        .clk    (clk),
        .rst    (rst),
        .done_i (done),
        .vld_o  (smp_vld_o)
    );

    assign conv_n_o   = strb.conv_n;
    assign cs_n_o     = strb.cs_n;
    assign rd_n_o     = strb.rd_n;
    assign byte_sel_o = strb.bsel;

endmodule

// File: rtl/adc_par_ctrl_chk.sv
module adc_par_ctrl_chk #(
    parameter int CONV_CYC = 5,
    parameter int PRE_CYC  = 13,
    parameter int POST_CYC = 10
) (
    input logic clk,
    input logic rst,
    input logic conv_n,
    input logic cs_n,
    input logic rd_n,
    input logic busy,
    input logic vld,
    input logic tmo,
    input logic ready
);

    localparam int SAT = 65535;

    logic conv_q, rd_q;
    int   lo_len, since_cf, since_rr;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_q   <= 1'b1;
            rd_q     <= 1'b1;
            lo_len   <= 0;
            since_cf <= SAT;
            since_rr <= SAT;
        end else begin
            conv_q <= conv_n;
            rd_q   <= rd_n;
            lo_len <= conv_n ? 0 : lo_len + 1;
            if (conv_q && !conv_n)  since_cf <= 0;
            else if (since_cf < SAT) since_cf <= since_cf + 1;
            if (rd_n && !rd_q)      since_rr <= 0;
            else if (since_rr < SAT) since_rr <= since_rr + 1;
        end
    end

    p_conv_cs_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_n) |-> !cs_n);

    p_conv_width_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_n) |-> lo_len >= CONV_CYC);

    p_rd_post_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n) |-> since_cf >= POST_CYC);

    p_rd_busy_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !busy);

    p_quiet_pre_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_n) |-> since_rr >= PRE_CYC);

    p_vld_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld);

    p_tmo_novld_r9: assert property (@(posedge clk) disable iff (rst)
        tmo |-> !vld);

    p_tmo_ready_r9: assert property (@(posedge clk) disable iff (rst)
        tmo |=> ready && !tmo);

    p_rd_cs_r12: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !cs_n);

endmodule

bind adc_par_ctrl adc_par_ctrl_chk #(
    .CONV_CYC (CONV_CYC),
    .PRE_CYC  (PRE_CYC),
    .POST_CYC (POST_CYC)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .conv_n (conv_n_o),
    .cs_n   (cs_n_o),
    .rd_n   (rd_n_o),
    .busy   (busy_i),
    .vld    (smp_vld_o),
    .tmo    (busy_tmo_o),
    .ready  (ready_o)
);

// File: tb/adc_par_ctrl_bench.sv
module adc_par_ctrl_bench;

    localparam int NV = 8;
    // {code, byte_mode, rd_hold, busy_len}
    localparam logic [25:0] VEC [NV] = '{
        {16'h0000, 1'b0, 1'b0, 8'd8},
        {16'hFFFF, 1'b0, 1'b0, 8'd8},
        {16'h8000, 1'b1, 1'b0, 8'd12},
        {16'h7FFF, 1'b1, 1'b1, 8'd12},
        {16'hA55A, 1'b1, 1'b0, 8'd3},
        {16'h1234, 1'b0, 1'b1, 8'd20},
        {16'hC3E1, 1'b1, 1'b1, 8'd30},
        {16'h0F0F, 1'b0, 1'b0, 8'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, byte_mode = 1'b0, rd_hold = 1'b0;
    logic        busy = 1'b0;
    logic [15:0] db;
    logic        conv_n, cs_n, rd_n, bsel, vld, tmo, ready;
    logic [15:0] smp;

    always #2 clk = ~clk;

    adc_par_ctrl u_adc_par_ctrl (
        .clk (clk), .rst (rst), .start_i (start), .byte_mode_i (byte_mode),
        .rd_hold_i (rd_hold), .busy_i (busy), .db_i (db),
        .conv_n_o (conv_n), .cs_n_o (cs_n), .rd_n_o (rd_n), .byte_sel_o (bsel),
        .smp_o (smp), .smp_vld_o (vld), .busy_tmo_o (tmo), .ready_o (ready)
    );

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // converter model
    logic [15:0] code = 16'h0;
    int          blen = 4;
    int          bcnt = 0;
    logic        stuck = 1'b0;
    logic        cv_prev = 1'b1;

    always @(negedge clk) begin
        cv_prev <= conv_n;
        if (cv_prev && !conv_n) begin
            busy <= 1'b1;
            bcnt <= blen;
        end else if (busy && !stuck) begin
            if (bcnt <= 1) busy <= 1'b0;
            else           bcnt <= bcnt - 1;
        end
    end

    assign db = (!cs_n && !rd_n) ? (bsel ? {code[7:0], 8'h5A} : code) : 16'hBEEF;

    // port monitor
    logic        mp_conv = 1'b1, mp_rd = 1'b1;
    int          conv_falls = 0, rd_falls = 0, conv_lo = 0;
    int          since_cf = 1000, since_rr = 1000;
    int          viol_r1 = 0, viol_r2 = 0, viol_r3 = 0;
    int          vld_cnt = 0, tmo_cnt = 0;
    logic [15:0] last_data = 16'h0;

    always @(negedge clk) begin
        if (rst) begin
            since_rr = 1000;
            conv_lo  = 0;
        end else begin
            if (mp_conv && !conv_n) begin
                conv_falls++;
                if (cs_n) viol_r1++;
                if (since_rr < 13) viol_r3++;
                since_cf = 0;
            end else if (since_cf < 1000) begin
                since_cf++;
            end
            if (!conv_n) conv_lo++;
            else begin
                if (!mp_conv && conv_lo < 5) viol_r1++;
                conv_lo = 0;
            end
            if (mp_rd && !rd_n) begin
                rd_falls++;
                if (since_cf < 10 || busy) viol_r2++;
            end
            if (!mp_rd && rd_n) since_rr = 0;
            else if (since_rr < 1000) since_rr++;
            if (vld) begin
                vld_cnt++;
                last_data = smp;
            end
            if (tmo) tmo_cnt++;
        end
        mp_conv = conv_n;
        mp_rd   = rd_n;
    end

    task automatic do_conv(input logic [15:0] c, input bit bm, input bit hold, input int l);
        @(negedge clk);
        code = c; blen = l; byte_mode = bm; rd_hold = hold; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (1) @(negedge clk);
        // R11: reset state {conv,cs,rd,bsel,vld,ready,tmo}
        chk({conv_n, cs_n, rd_n, bsel, vld, ready, tmo} == 7'b1110010 && smp == 16'h0,
            "R11 reset outputs", {conv_n, cs_n, rd_n, bsel, vld, ready, tmo}, 7'b1110010);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({conv_n, cs_n, rd_n, ready} == 4'b1111, "R11 after reset", {conv_n, cs_n, rd_n, ready}, 4'hF);

        // R7: warm-up reads give no valid
        for (int i = 0; i < 3; i++) do_conv(16'h1000 + 16'(i), 1'b0, 1'b0, 6);
        chk(vld_cnt == 0, "R7 discard three", vld_cnt, 0);
        chk(rd_falls == 3, "R4 warm-up reads done", rd_falls, 3);

        // table of vectors
        for (int k = 0; k < NV; k++) begin
            logic [15:0] c;
            bit          bm, hold;
            int          l, v0, r0, exp_rf;
            c = VEC[k][25:10]; bm = VEC[k][9]; hold = VEC[k][8]; l = int'(VEC[k][7:0]);
            v0 = vld_cnt; r0 = rd_falls;
            do_conv(c, bm, hold, l);
            exp_rf = (bm && !hold) ? 2 : 1;
            chk(vld_cnt - v0 == 1, "R8 one valid pulse", vld_cnt - v0, 1);
            chk(last_data == c, bm ? "R5 byte data" : "R4 word data", last_data, c);
            chk(rd_falls - r0 == exp_rf, "R6 read strobe edges", rd_falls - r0, exp_rf);
        end

        // R9: busy stuck high
        begin
            int v0, r0, t0;
            v0 = vld_cnt; r0 = rd_falls; t0 = tmo_cnt;
            stuck = 1'b1;
            do_conv(16'h1111, 1'b0, 1'b0, 5);
            chk(tmo_cnt - t0 == 1, "R9 timeout pulse", tmo_cnt - t0, 1);
            chk(vld_cnt == v0 && rd_falls == r0, "R9 no read after timeout", rd_falls - r0, 0);
            chk(ready == 1'b1, "R9 ready after timeout", ready, 1);
            stuck = 1'b0;
            repeat (10) @(negedge clk);
            do_conv(16'h2222, 1'b1, 1'b0, 4);
            chk(last_data == 16'h2222 && vld_cnt - v0 == 1, "R9 recovery", last_data, 16'h2222);
        end

        // R10: start while busy is ignored
        begin
            int c0, v0;
            c0 = conv_falls; v0 = vld_cnt;
            @(negedge clk);
            code = 16'h3C3C; blen = 10; byte_mode = 1'b0; rd_hold = 1'b0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (!ready) @(negedge clk);
            repeat (30) @(negedge clk);
            chk(conv_falls - c0 == 1, "R10 start ignored", conv_falls - c0, 1);
            chk(vld_cnt - v0 == 1 && last_data == 16'h3C3C, "R10 single result", vld_cnt - v0, 1);
        end

        // R7: discard restarts after a second reset
        do_reset();
        begin
            int v0;
            v0 = vld_cnt;
            for (int i = 0; i < 3; i++) do_conv(16'h4444, 1'b1, 1'b1, 5);
            chk(vld_cnt == v0, "R7 discard after re-reset", vld_cnt - v0, 0);
            do_conv(16'h5A5A, 1'b1, 1'b1, 5);
            chk(vld_cnt - v0 == 1 && last_data == 16'h5A5A, "R7 fourth result valid", last_data, 16'h5A5A);
        end

        chk(viol_r1 == 0, "R1 strobe width and select", viol_r1, 0);
        chk(viol_r2 == 0, "R2 read after busy and quiet window", viol_r2, 0);
        chk(viol_r3 == 0, "R3 quiet before start", viol_r3, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule